// File: doc/BRIEF.md
# Asynchronous SRAM ring-buffer controller

This block turns an external asynchronous static RAM (18-bit word address, 16-bit data by default) into a large circular sample store. Each sample offered on the write port is written at the next position of a wrapping write counter. The same sequence then reads one word back at the current read pointer and presents it on a read-data output with a one-cycle valid flag. Both operations run from a single synchronous clock through a fixed five-step sequence.

The read pointer does not advance by one the way a FIFO pointer does. It moves by a programmable jump, modulo the address space, each time the sampling-period tick is asserted. Between ticks every read returns the word at the same position. A jump that arrives while a read is in progress takes effect from the next read.

The controller owns the tri-state data bus. It releases the bus before the read half of every sequence, so the RAM and the controller never drive it at the same time. Chip enable and output enable stay asserted at all times. Writes are framed only by the write-enable pulse and the byte enables.

Top module: `sram_ring_ctrl`

States of the sequencer:

- IDLE: no sequence in progress.
- W_SETUP (step 0)
- W_STROBE (step 1)
- W_RELEASE (step 2)
- R_ADDR (step 3)
- R_CAPTURE (step 4)

Transitions:

- IDLE goes to W_SETUP when a sample is accepted.
- W_SETUP goes to W_STROBE, then W_RELEASE, then R_ADDR, then R_CAPTURE. These steps are unconditional.
- R_CAPTURE goes to W_SETUP when a new sample is accepted, and to IDLE otherwise.

## Requirements
- R1: While reset is asserted and just after it, rd_valid_o is 0 and we/lb/ub are all 1 (inactive). The write counter and the read pointer both start at 0, so the first write goes to address 0 and the first read comes from address 0.
- R2: A sample with wr_valid_i=1 is accepted only in IDLE or R_CAPTURE. Once accepted, steps 0 to 4 follow in five consecutive cycles, starting the cycle after acceptance. A wr_valid_i seen in any other state is ignored: it starts no sequence and consumes no write address.
- R3: In step 0, sram_addr_o equals the write counter, the bus carries the accepted sample, and we, lb and ub are all 1.
- R4: In step 1, we, lb and ub are all 0. In step 2 they are all 1 again. Address and data stay unchanged through steps 0 to 2.
- R5: The write counter adds one at the end of step 2 and wraps from 2^ADDR_W-1 to 0.
- R6: In steps 3 and 4, the controller releases the bus, we is 1, lb and ub are 0, and sram_addr_o holds the read pointer as it stood at the end of step 2.
- R7: rd_data_o takes the bus value sampled at the end of step 4. rd_valid_o is 1 for exactly the cycle after step 4.
- R8: Each cycle with period_tick_i=1 sets the read pointer to (pointer + jump_i) mod 2^ADDR_W. A tick during steps 3 and 4 leaves the read in progress unchanged.
- R9: sram_ce_n_o and sram_oe_n_o are 0 at all times.
- R10: In IDLE, we, lb and ub are 1 and the controller does not drive the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| wr_valid_i | input | 1 | Sample offered this cycle |
| wr_data_i | input | DATA_W | Sample value |
| period_tick_i | input | 1 | Sampling-period tick that displaces the read pointer |
| jump_i | input | ADDR_W | Read-pointer displacement |
| rd_data_o | output | DATA_W | Word read back |
| rd_valid_o | output | 1 | rd_data_o is new this cycle |
| sram_addr_o | output | ADDR_W | RAM address |
| sram_dq_io | inout | DATA_W | RAM data bus |
| sram_ce_n_o | output | 1 | Chip enable, active low |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_we_n_o | output | 1 | Write enable, active low |
| sram_lb_n_o | output | 1 | Lower byte enable, active low |
| sram_ub_n_o | output | 1 | Upper byte enable, active low |

## Verification
The bench offers a sample in the cycle before edge E0 and then checks each step in the cycle where it is due:

| Result | Due in the cycle after edge |
|---|---|
| Step 0 bus contents | E0 |
| Write strobe low | E1 |
| Strobe released | E2 |
| Read address on the bus | E3 |
| Read address still held | E4 |
| rd_valid_o pulse with the read word | E5 |
| Flag dropped | E6 |

Inputs change on the falling clock edge, and every check samples on the falling edge of the cycle it targets. No result is read at the edge that produces it. Back-to-back samples are checked to start a new step 0 every five cycles. The wrap of the write counter is checked on a second instance with a 6-bit address.

// File: rtl/sram_ring_pkg.sv
package sram_ring_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_W_SETUP   = 3'd1,
        ST_W_STROBE  = 3'd2,
        ST_W_RELEASE = 3'd3,
        ST_R_ADDR    = 3'd4,
        ST_R_CAPTURE = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic we_n;
        logic lb_n;
        logic ub_n;
        logic drive_bus;
        logic sel_read;
        logic wr_inc;
        logic rd_latch;
        logic capture;
    } seq_ctrl_t;

    localparam seq_ctrl_t CTRL_IDLE = '{
        we_n: 1'b1, lb_n: 1'b1, ub_n: 1'b1, drive_bus: 1'b0,
        sel_read: 1'b1, wr_inc: 1'b0, rd_latch: 1'b0, capture: 1'b0
    };

endpackage

// File: rtl/sram_wr_addr_ctr.sv
module sram_wr_addr_ctr #(
    parameter int ADDR_W = 18
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              inc_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            addr_o <= '0;
        end else if (inc_i) begin
            addr_o <= addr_o + ONE;
        end
    end

    // R5
    wr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        inc_i |=> addr_o == $past(addr_o) + ONE);

    // R5
    wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !inc_i |=> $stable(addr_o));

endmodule

// File: rtl/sram_rd_ptr_gen.sv
module sram_rd_ptr_gen #(
    parameter int ADDR_W = 18
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] jump_i,
    input  logic              latch_i,
    output logic [ADDR_W-1:0] rd_addr_o
);

    logic [ADDR_W-1:0] ptr_q;

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            ptr_q <= '0;
        end else if (tick_i) begin
            ptr_q <= ptr_q + jump_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            rd_addr_o <= '0;
        end else if (latch_i) begin
            rd_addr_o <= ptr_q;
        end
    end

    // R8
    ptr_jump_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        tick_i |=> ptr_q == $past(ptr_q) + $past(jump_i));

    // R8
    rd_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !latch_i |=> $stable(rd_addr_o));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ring_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_n_i,
    input  logic      start_i,
    output logic      accept_o,
    output seq_ctrl_t ctrl_o
);

    seq_state_e state_q, state_d;

    assign accept_o = start_i && (state_q == ST_IDLE || state_q == ST_R_CAPTURE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      state_d = accept_o ? ST_W_SETUP : ST_IDLE;
            ST_W_SETUP:   state_d = ST_W_STROBE;
            ST_W_STROBE:  state_d = ST_W_RELEASE;
            ST_W_RELEASE: state_d = ST_R_ADDR;
            ST_R_ADDR:    state_d = ST_R_CAPTURE;
            ST_R_CAPTURE: state_d = accept_o ? ST_W_SETUP : ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ctrl_o = CTRL_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                ctrl_o = CTRL_IDLE;
            end
            ST_W_SETUP: begin
                ctrl_o.drive_bus = 1'b1;
                ctrl_o.sel_read  = 1'b0;
            end
            ST_W_STROBE: begin
                ctrl_o.drive_bus = 1'b1;
                ctrl_o.sel_read  = 1'b0;
                ctrl_o.we_n      = 1'b0;
                ctrl_o.lb_n      = 1'b0;
                ctrl_o.ub_n      = 1'b0;
            end
            ST_W_RELEASE: begin
                ctrl_o.drive_bus = 1'b1;
                ctrl_o.sel_read  = 1'b0;
                ctrl_o.wr_inc    = 1'b1;
                ctrl_o.rd_latch  = 1'b1;
            end
            ST_R_ADDR: begin
                ctrl_o.lb_n = 1'b0;
                ctrl_o.ub_n = 1'b0;
            end
            ST_R_CAPTURE: begin
                ctrl_o.lb_n    = 1'b0;
                ctrl_o.ub_n    = 1'b0;
                ctrl_o.capture = 1'b1;
            end
            default: ctrl_o = CTRL_IDLE;
        endcase
    end

    // R2
    busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q != ST_IDLE && state_q != ST_R_CAPTURE) |=> state_q != ST_W_SETUP);

    // R2
    seq_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == ST_W_SETUP) |=> (state_q == ST_W_STROBE));

endmodule

// File: rtl/sram_ring_ctrl.sv
module sram_ring_ctrl
    import sram_ring_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              wr_valid_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              period_tick_i,
    input  logic [ADDR_W-1:0] jump_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic [ADDR_W-1:0] sram_addr_o,
    inout  wire  [DATA_W-1:0] sram_dq_io,
    output logic              sram_ce_n_o,
    output logic              sram_oe_n_o,
    output logic              sram_we_n_o,
    output logic              sram_lb_n_o,
    output logic              sram_ub_n_o
);

    localparam logic [DATA_W-1:0] BUS_FREE = {DATA_W{1'bz}};

    seq_ctrl_t         ctrl;
    logic              accept;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] wr_data_q;

    sram_seq_fsm u_seq (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .start_i  (wr_valid_i),
        .accept_o (accept),
        .ctrl_o   (ctrl)
    );

    sram_wr_addr_ctr #(.ADDR_W(ADDR_W)) u_wr_ctr (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .inc_i   (ctrl.wr_inc),
        .addr_o  (wr_addr)
    );

    sram_rd_ptr_gen #(.ADDR_W(ADDR_W)) u_rd_ptr (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .tick_i    (period_tick_i),
        .jump_i    (jump_i),
        .latch_i   (ctrl.rd_latch),
        .rd_addr_o (rd_addr)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            wr_data_q <= '0;
        end else if (accept) begin
            wr_data_q <= wr_data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= ctrl.capture;
            if (ctrl.capture) begin
                rd_data_o <= sram_dq_io;
            end
        end
    end

    assign sram_dq_io  = ctrl.drive_bus ? wr_data_q : BUS_FREE;
    assign sram_addr_o = ctrl.sel_read ? rd_addr : wr_addr;
    assign sram_ce_n_o = 1'b0;
    assign sram_oe_n_o = 1'b0;
    assign sram_we_n_o = ctrl.we_n;
    assign sram_lb_n_o = ctrl.lb_n;
    assign sram_ub_n_o = ctrl.ub_n;

    // R4
    strobe_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(sram_we_n_o) |-> $stable(sram_addr_o) && $past(ctrl.drive_bus));

    // R4
    strobe_width_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !sram_we_n_o |=> sram_we_n_o && $stable(sram_addr_o));

    // R6
    bus_turnaround_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!sram_lb_n_o && sram_we_n_o) |-> !ctrl.drive_bus);

    // R7
    rd_valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        rd_valid_o |=> !rd_valid_o);

endmodule

// File: tb/sram_ring_ctrl_bench.sv
module sram_ring_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data = '0;
    logic        tick = 1'b0;
    logic [17:0] jump = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic [17:0] addr;
    wire  [15:0] dq;
    logic        ce_n, oe_n, we_n, lb_n, ub_n;

    logic        s_valid = 1'b0;
    logic [15:0] s_rd_data;
    logic        s_rd_valid;
    logic [5:0]  s_addr;
    wire  [15:0] s_dq;
    logic        s_ce_n, s_oe_n, s_we_n, s_lb_n, s_ub_n;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    sram_ring_ctrl u_sram_ring_ctrl (
        .clk_i(clk), .rst_n_i(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
        .period_tick_i(tick), .jump_i(jump), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
        .sram_addr_o(addr), .sram_dq_io(dq), .sram_ce_n_o(ce_n), .sram_oe_n_o(oe_n),
        .sram_we_n_o(we_n), .sram_lb_n_o(lb_n), .sram_ub_n_o(ub_n)
    );

    sram_ring_ctrl #(.ADDR_W(6), .DATA_W(16)) u_sram_ring_ctrl_small (
        .clk_i(clk), .rst_n_i(rst_n), .wr_valid_i(s_valid), .wr_data_i(16'h0F0F),
        .period_tick_i(1'b0), .jump_i(6'd0), .rd_data_o(s_rd_data), .rd_valid_o(s_rd_valid),
        .sram_addr_o(s_addr), .sram_dq_io(s_dq), .sram_ce_n_o(s_ce_n), .sram_oe_n_o(s_oe_n),
        .sram_we_n_o(s_we_n), .sram_lb_n_o(s_lb_n), .sram_ub_n_o(s_ub_n)
    );

    // Behavioural RAM: writes while the strobe is low, presents read data on the falling edge.
    logic [15:0] mem [logic [17:0]];
    logic [15:0] model_q = '0;
    logic        model_drv;
    assign model_drv = !oe_n && !ce_n && we_n && !lb_n && !ub_n;
    assign dq = model_drv ? model_q : 16'hzzzz;

    always @(negedge clk) begin
        if (!we_n && !ce_n && !lb_n && !ub_n) mem[addr] = dq;
        if (mem.exists(addr)) model_q = mem[addr];
        else model_q = 16'h0000;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            chk(1'b0, "R2 watchdog expired", cyc, 0);
            summary();
            $finish;
        end
    end

    // One full write-then-read sequence with checks at every step.
    task automatic do_seq(input logic tk, input logic [17:0] j, input logic [15:0] d,
                          input logic [17:0] ewa, input logic [17:0] era, input logic [15:0] erd,
                          input bit inj_busy, input bit inj_tick, input logic [17:0] mj);
        @(negedge clk); tick = tk; jump = j;
        @(negedge clk); tick = 1'b0; wr_valid = 1'b1; wr_data = d;
        @(negedge clk); wr_valid = 1'b0;
        chk(addr == ewa, "R3 step0 address", addr, ewa);
        chk(dq == d, "R3 step0 data", dq, d);
        chk({we_n, lb_n, ub_n} == 3'b111, "R3 step0 controls", {we_n, lb_n, ub_n}, 3'b111);
        if (inj_busy) begin wr_valid = 1'b1; wr_data = 16'hBBBB; end
        @(negedge clk); wr_valid = 1'b0;
        chk({we_n, lb_n, ub_n} == 3'b000, "R4 step1 controls", {we_n, lb_n, ub_n}, 3'b000);
        chk(addr == ewa && dq == d, "R4 step1 addr/data held", {addr, dq[13:0]}, {ewa, d[13:0]});
        @(negedge clk);
        chk({we_n, lb_n, ub_n} == 3'b111, "R4 step2 controls", {we_n, lb_n, ub_n}, 3'b111);
        chk(addr == ewa, "R4 step2 address", addr, ewa);
        @(negedge clk);
        chk({we_n, lb_n, ub_n} == 3'b100, "R6 step3 controls", {we_n, lb_n, ub_n}, 3'b100);
        chk(addr == era, "R6 step3 read address", addr, era);
        if (inj_tick) begin tick = 1'b1; jump = mj; end
        @(negedge clk); tick = 1'b0;
        chk(addr == era, "R8 step4 address unchanged", addr, era);
        chk(rd_valid == 1'b0, "R7 valid not early", rd_valid, 0);
        @(negedge clk);
        chk(rd_valid == 1'b1, "R7 valid raised", rd_valid, 1);
        chk(rd_data == erd, "R7 read data", rd_data, erd);
        chk({we_n, lb_n, ub_n} == 3'b111, "R10 idle controls", {we_n, lb_n, ub_n}, 3'b111);
        chk({ce_n, oe_n} == 2'b00, "R9 ce/oe low", {ce_n, oe_n}, 0);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R7 valid one cycle", rd_valid, 0);
        chk(lb_n == 1'b1, "R2 no extra sequence", lb_n, 1);
    endtask

    // tick, jump, wdata, write addr, read addr, read data
    localparam logic [86:0] VECS [8] = '{
        {1'b0, 18'h00000, 16'h1111, 18'd0, 18'd0, 16'h1111},
        {1'b0, 18'h00000, 16'h2222, 18'd1, 18'd0, 16'h1111},
        {1'b1, 18'h00001, 16'h3333, 18'd2, 18'd1, 16'h2222},
        {1'b1, 18'h00002, 16'h4444, 18'd3, 18'd3, 16'h4444},
        {1'b1, 18'h3FFFE, 16'h5555, 18'd4, 18'd1, 16'h2222},
        {1'b1, 18'h3FFFF, 16'h6666, 18'd5, 18'd0, 16'h1111},
        {1'b1, 18'h00005, 16'h7777, 18'd6, 18'd5, 16'h6666},
        {1'b1, 18'h00002, 16'h8888, 18'd7, 18'd7, 16'h8888}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rd_valid == 1'b0, "R1 reset valid", rd_valid, 0);
        chk({we_n, lb_n, ub_n} == 3'b111, "R1 reset controls", {we_n, lb_n, ub_n}, 3'b111);
        chk({ce_n, oe_n} == 2'b00, "R9 ce/oe low in reset", {ce_n, oe_n}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({we_n, lb_n, ub_n} == 3'b111, "R10 idle after reset", {we_n, lb_n, ub_n}, 3'b111);

        // Table walk: R1 (first addresses 0), R3..R8
        for (int i = 0; i < 8; i++) begin
            do_seq(VECS[i][86], VECS[i][85:68], VECS[i][67:52], VECS[i][51:34],
                   VECS[i][33:16], VECS[i][15:0], 1'b0, 1'b0, '0);
        end

        // R2: sample offered mid-sequence is ignored, next write uses address 9
        do_seq(1'b0, '0, 16'hAAAA, 18'd8, 18'd7, 16'h8888, 1'b1, 1'b0, '0);
        do_seq(1'b0, '0, 16'hCCCC, 18'd9, 18'd7, 16'h8888, 1'b0, 1'b0, '0);

        // R8: tick during a read leaves it alone, next read uses 7+3
        do_seq(1'b0, '0, 16'hDDDD, 18'd10, 18'd7, 16'h8888, 1'b0, 1'b1, 18'd3);
        do_seq(1'b0, '0, 16'hEEEE, 18'd11, 18'd10, 16'hDDDD, 1'b0, 1'b0, '0);

        // R5 wrap and R2 back-to-back on the 6-bit instance
        @(negedge clk); s_valid = 1'b1;
        for (int k = 0; k <= 64; k++) begin
            @(negedge clk);
            if (k == 0 || k == 1 || k == 63 || k == 64) begin
                chk(s_addr == 6'(k % 64), "R5 write counter wrap", s_addr, k % 64);
                chk(s_we_n && s_lb_n, "R2 back-to-back step0", {s_we_n, s_lb_n}, 2'b11);
            end
            repeat (4) @(negedge clk);
        end
        s_valid = 1'b0;

        summary();
        $finish;
    end

endmodule